// File: doc/BRIEF.md
# Shared Debug Control Register Bank

This block holds the debug control registers of a processor's on-chip debug unit. Two masters can write them. The external debug host uses register-write and register-read commands that select a register with a 4-bit code. The on-chip processor uses a supervisor-mode debug-write path. The register bank sits between these two masters and the breakpoint logic, which reads the breakpoint attribute, address and data values straight from the bank's outputs.

Three registers serve two purposes: breakpoint attributes, the breakpoint address, and breakpoint data. The host's memory-access commands place their bus attributes, address and write data in these same registers through a separate load port. A memory command therefore destroys whatever breakpoint was stored there. Each load raises a one-cycle `bp_clobber` pulse so that the breakpoint logic can disarm itself.

The host can set a lock bit in the control register. While the lock is set, processor writes to the breakpoint registers are ignored. The two masters are expected to take turns. If both still write in the same cycle, the host side wins and a sticky conflict flag records the collision.

Top module: `dbg_regbank`

## Requirements
- R1: After reset, every register reads zero, and `lock`, `conflict` and `bp_clobber` are all 0.
- R2: A host write to select code 0 to 8 can be read back on `host_rdata` in the following cycle. Codes 2 to 7 store all 32 bits. Codes 1 (attributes) and 8 (trigger) store bits 15:0 only, and their upper bits read as zero. Code 0 (control) stores bits 15:0 except bit 1.
- R3: Select codes 9 to 15 read as zero. A host write to one of these codes changes no register.
- R4: When the lock is clear, a processor write to codes 1 to 8 updates the register in the same way a host write does. A processor write to code 0 updates bits 15:2 of the control register but never changes bit 0 or bit 1.
- R5: Control bit 0 is the lock, and `lock` shows its value. While the lock is 1, processor writes to codes 1 to 8 are ignored.
- R6: When `proc_we` is high in the same cycle as `host_we` or `mem_ld_valid`, the processor write is dropped. The host or load write still takes effect, and `conflict` becomes 1 in the next cycle. Control bit 1 reads the same value as `conflict`. The flag stays set until the host writes code 0 with bit 1 = 1. If a new conflict happens in the same cycle as that clear, the flag stays set.
- R7: On a memory load (`mem_ld_valid`), `mem_ld_attr` is written to code 1 and `mem_ld_addr` to code 2. When `mem_ld_write` is 1, `mem_ld_data` is also written to code 4. A load takes priority over a host write to the same register in the same cycle.
- R8: `bp_clobber` is high for exactly the one cycle after each cycle in which `mem_ld_valid` is high.
- R9: `bp_attr`, `bp_addr` and `bp_data` always show the current contents of codes 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register-write strobe |
| host_sel | input | 4 | Host register select code |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_sel` (combinational) |
| proc_we | input | 1 | Processor debug-write strobe |
| proc_sel | input | 4 | Processor register select code |
| proc_wdata | input | 32 | Processor write data |
| mem_ld_valid | input | 1 | Host memory command loads the shared registers |
| mem_ld_write | input | 1 | The memory command is a write, so the data register is loaded too |
| mem_ld_attr | input | 16 | Bus attributes of the memory command |
| mem_ld_addr | input | 32 | Address of the memory command |
| mem_ld_data | input | 32 | Write data of the memory command |
| lock | output | 1 | Processor write lock (control bit 0) |
| conflict | output | 1 | Sticky flag for a same-cycle write collision |
| bp_clobber | output | 1 | One-cycle pulse after each memory load |
| bp_attr | output | 16 | Breakpoint attributes to the comparators |
| bp_addr | output | 32 | Breakpoint address to the comparators |
| bp_data | output | 32 | Breakpoint data to the comparators |

## Verification
The bench builds the block with its default parameters. These are nine registers, a 4-bit select code, a 32-bit data path and 16-bit narrow registers. With these values, all seven unused select codes can be tried, and so can the truncation of both narrow registers. The defaults also bring within reach every collision between the three write sources (host, processor and load) on the shared address register, including a conflict that lands in the same cycle as its own clear.

// File: rtl/dbg_regbank_pkg.sv
package dbg_regbank_pkg;
    localparam int REGS_DEF   = 9;
    localparam int SEL_W_DEF  = 4;
    localparam int DATA_W_DEF = 32;
    localparam int NARROW_DEF = 16;

    localparam int IDX_CTRL    = 0;
    localparam int IDX_ATTR    = 1;
    localparam int IDX_ADDR_HI = 2;
    localparam int IDX_ADDR_LO = 3;
    localparam int IDX_DATA    = 4;
    localparam int IDX_DMASK   = 5;
    localparam int IDX_PC      = 6;
    localparam int IDX_PCMASK  = 7;
    localparam int IDX_TRIG    = 8;

    localparam int BIT_LOCK     = 0;
    localparam int BIT_CONFLICT = 1;
endpackage

// File: rtl/dbg_regbank_wr_arb.sv
module dbg_regbank_wr_arb
    import dbg_regbank_pkg::*;
#(
    parameter int NUM_REGS = REGS_DEF,
    parameter int SEL_W    = SEL_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NARROW_W = NARROW_DEF
) (
    input  logic                            host_we,
    input  logic [SEL_W-1:0]                host_sel,
    input  logic [DATA_W-1:0]               host_wdata,
    input  logic                            proc_we,
    input  logic [SEL_W-1:0]                proc_sel,
    input  logic [DATA_W-1:0]               proc_wdata,
    input  logic                            lock,
    input  logic [DATA_W-1:0]               cur_ctrl,
    input  logic                            mem_ld_valid,
    input  logic                            mem_ld_write,
    input  logic [NARROW_W-1:0]             mem_ld_attr,
    input  logic [DATA_W-1:0]               mem_ld_addr,
    input  logic [DATA_W-1:0]               mem_ld_data,
    output logic [NUM_REGS-1:0]             wr_en,
    output logic [NUM_REGS-1:0][DATA_W-1:0] wr_val,
    output logic                            conflict_set,
    output logic                            conflict_clr
);
    localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});
    localparam logic [DATA_W-1:0] CTRL_MASK   = NARROW_MASK & ~(DATA_W'(1) << BIT_CONFLICT);
    localparam logic [DATA_W-1:0] LOCK_KEEP   = DATA_W'(1) << BIT_LOCK;

    logic proc_blocked;
    assign proc_blocked = host_we | mem_ld_valid;
    assign conflict_set = proc_we & proc_blocked;
    assign conflict_clr = host_we && (host_sel == SEL_W'(IDX_CTRL)) && host_wdata[BIT_CONFLICT];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam bit IS_NARROW = (i == IDX_ATTR) || (i == IDX_TRIG);
        localparam logic [DATA_W-1:0] STORE_MASK =
            (i == IDX_CTRL) ? CTRL_MASK : (IS_NARROW ? NARROW_MASK : '1);

        logic host_hit, proc_hit, mem_hit;
        logic [DATA_W-1:0] raw_d;

        assign host_hit = host_we && (host_sel == SEL_W'(i));
        assign proc_hit = proc_we && !proc_blocked && (proc_sel == SEL_W'(i)) &&
                          ((i == IDX_CTRL) || !lock);
        assign mem_hit  = mem_ld_valid &&
                          ((i == IDX_ATTR) || (i == IDX_ADDR_HI) ||
                           ((i == IDX_DATA) && mem_ld_write));

        always_comb begin
            raw_d = proc_wdata;
            if (mem_hit) begin
                if (i == IDX_ATTR)         raw_d = DATA_W'(mem_ld_attr);
                else if (i == IDX_ADDR_HI) raw_d = mem_ld_addr;
                else                       raw_d = mem_ld_data;
            end else if (host_hit) begin
                raw_d = host_wdata;
            end else if (i == IDX_CTRL) begin
                raw_d = (proc_wdata & ~LOCK_KEEP) | (cur_ctrl & LOCK_KEEP);
            end
        end

        assign wr_en[i]  = mem_hit | host_hit | proc_hit;
        assign wr_val[i] = raw_d & STORE_MASK;
    end
endmodule

// File: rtl/dbg_regbank_rd_mux.sv
module dbg_regbank_rd_mux
    import dbg_regbank_pkg::*;
#(
    parameter int NUM_REGS = REGS_DEF,
    parameter int SEL_W    = SEL_W_DEF,
    parameter int DATA_W   = DATA_W_DEF
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic                            conflict,
    input  logic [SEL_W-1:0]                sel,
    output logic [DATA_W-1:0]               rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == SEL_W'(i)) rdata = regs[i];
        end
        if (sel == SEL_W'(IDX_CTRL)) rdata[BIT_CONFLICT] = conflict;
    end
endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
    import dbg_regbank_pkg::*;
#(
    parameter int NUM_REGS = REGS_DEF,
    parameter int SEL_W    = SEL_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NARROW_W = NARROW_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [SEL_W-1:0]    host_sel,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                proc_we,
    input  logic [SEL_W-1:0]    proc_sel,
    input  logic [DATA_W-1:0]   proc_wdata,
    input  logic                mem_ld_valid,
    input  logic                mem_ld_write,
    input  logic [NARROW_W-1:0] mem_ld_attr,
    input  logic [DATA_W-1:0]   mem_ld_addr,
    input  logic [DATA_W-1:0]   mem_ld_data,
    output logic                lock,
    output logic                conflict,
    output logic                bp_clobber,
    output logic [NARROW_W-1:0] bp_attr,
    output logic [DATA_W-1:0]   bp_addr,
    output logic [DATA_W-1:0]   bp_data
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            conflict;
        logic                            clobber;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_REGS-1:0]             wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] wr_val;
    logic                            conflict_set, conflict_clr;

    dbg_regbank_wr_arb #(
        .NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)
    ) u_wr_arb (
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .proc_we     (proc_we),
        .proc_sel    (proc_sel),
        .proc_wdata  (proc_wdata),
        .lock        (lock),
        .cur_ctrl    (st_q.regs[IDX_CTRL]),
        .mem_ld_valid(mem_ld_valid),
        .mem_ld_write(mem_ld_write),
        .mem_ld_attr (mem_ld_attr),
        .mem_ld_addr (mem_ld_addr),
        .mem_ld_data (mem_ld_data),
        .wr_en       (wr_en),
        .wr_val      (wr_val),
        .conflict_set(conflict_set),
        .conflict_clr(conflict_clr)
    );

    dbg_regbank_rd_mux #(
        .NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .DATA_W(DATA_W)
    ) u_rd_mux (
        .regs    (st_q.regs),
        .conflict(st_q.conflict),
        .sel     (host_sel),
        .rdata   (host_rdata)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en[i]) st_d.regs[i] = wr_val[i];
        end
        if (conflict_clr) st_d.conflict = 1'b0;
        if (conflict_set) st_d.conflict = 1'b1;
        st_d.clobber = mem_ld_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock       = st_q.regs[IDX_CTRL][BIT_LOCK];
    assign conflict   = st_q.conflict;
    assign bp_clobber = st_q.clobber;
    assign bp_attr    = st_q.regs[IDX_ATTR][NARROW_W-1:0];
    assign bp_addr    = st_q.regs[IDX_ADDR_HI];
    assign bp_data    = st_q.regs[IDX_DATA];

    assert_clobber_follows_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ld_valid |=> bp_clobber);
    assert_clobber_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ld_valid |=> !bp_clobber);
    assert_load_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ld_valid |=> (bp_addr == $past(mem_ld_addr)));
    assert_lock_holds_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && proc_we && !host_we && !mem_ld_valid && proc_sel == SEL_W'(IDX_ADDR_HI))
        |=> $stable(bp_addr));
    assert_host_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && proc_we && !mem_ld_valid && host_sel == SEL_W'(IDX_ADDR_HI))
        |=> (bp_addr == $past(host_wdata)));
    assert_conflict_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && !(host_we && host_sel == SEL_W'(IDX_CTRL) && host_wdata[BIT_CONFLICT]))
        |=> conflict);
    assert_conflict_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_we && (host_we || mem_ld_valid)) |=> conflict);

    always_comb begin
        if (rst_n && host_sel >= SEL_W'(NUM_REGS))
            assert_unused_zero_R3: assert (host_rdata == '0);
        if (rst_n && host_sel == SEL_W'(IDX_ATTR))
            assert_attr_narrow_R2: assert (host_rdata[DATA_W-1:NARROW_W] == '0);
    end
endmodule

// File: tb/dbg_regbank_bench.sv
`timescale 1ns/1ps
module dbg_regbank_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 0, proc_we = 0, mem_ld_valid = 0, mem_ld_write = 0;
    logic [3:0]  host_sel = 0, proc_sel = 0;
    logic [31:0] host_wdata = 0, proc_wdata = 0, mem_ld_addr = 0, mem_ld_data = 0;
    logic [15:0] mem_ld_attr = 0;
    logic [31:0] host_rdata, bp_addr, bp_data;
    logic [15:0] bp_attr;
    logic lock, conflict, bp_clobber;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m [9];

    always #2 clk = ~clk;

    dbg_regbank u_dbg_regbank (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .proc_we(proc_we), .proc_sel(proc_sel), .proc_wdata(proc_wdata),
        .mem_ld_valid(mem_ld_valid), .mem_ld_write(mem_ld_write), .mem_ld_attr(mem_ld_attr),
        .mem_ld_addr(mem_ld_addr), .mem_ld_data(mem_ld_data),
        .lock(lock), .conflict(conflict), .bp_clobber(bp_clobber),
        .bp_attr(bp_attr), .bp_addr(bp_addr), .bp_data(bp_data)
    );

    function automatic logic [31:0] smask(int i);
        if (i == 0) return 32'h0000_FFFD;
        if (i == 1 || i == 8) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(bit hwe, int hs, logic [31:0] hd, bit pwe, int ps, logic [31:0] pd,
                         bit lv, bit lw, logic [15:0] la, logic [31:0] ladr, logic [31:0] ld);
        @(negedge clk);
        host_we = hwe; host_sel = 4'(hs); host_wdata = hd;
        proc_we = pwe; proc_sel = 4'(ps); proc_wdata = pd;
        mem_ld_valid = lv; mem_ld_write = lw; mem_ld_attr = la; mem_ld_addr = ladr; mem_ld_data = ld;
        @(negedge clk);
        host_we = 0; proc_we = 0; mem_ld_valid = 0; mem_ld_write = 0;
    endtask

    task automatic rd(int sel, output logic [31:0] v);
        host_sel = 4'(sel);
        #0.5;
        v = host_rdata;
    endtask

    task automatic check_all(string req, bit cflag);
        logic [31:0] v;
        for (int i = 0; i < 9; i++) begin
            rd(i, v);
            check(req, v, (i == 0) ? (m[0] | {30'd0, cflag, 1'b0}) : m[i]);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 9; i++) m[i] = 0;
        check_all("R1", 1'b0);
        check("R1 lock", {31'd0, lock}, 0);
        check("R1 conflict", {31'd0, conflict}, 0);
        check("R1 clobber", {31'd0, bp_clobber}, 0);
    endtask

    task automatic t_host_rw;
        for (int i = 0; i < 9; i++) begin
            logic [31:0] d = 32'h9E37_79B8 ^ (32'(i) << 20) ^ (32'(i) << 4);
            apply(1, i, d, 0, 0, 0, 0, 0, 0, 0, 0);
            m[i] = d & smask(i);
        end
        check_all("R2", 1'b0);
    endtask

    task automatic t_unused;
        logic [31:0] v;
        for (int s = 9; s < 16; s++) apply(1, s, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int s = 9; s < 16; s++) begin
            rd(s, v);
            check("R3 read", v, 0);
        end
        check_all("R3 no write", 1'b0);
    endtask

    task automatic t_proc;
        apply(0, 0, 0, 1, 5, 32'h1234_5678, 0, 0, 0, 0, 0);
        m[5] = 32'h1234_5678;
        apply(0, 0, 0, 1, 8, 32'hABCD_EF01, 0, 0, 0, 0, 0);
        m[8] = 32'h0000_EF01;
        apply(0, 0, 0, 1, 0, 32'h0000_0F03, 0, 0, 0, 0, 0);
        m[0] = (32'h0000_0F03 & 32'h0000_FFFC) | (m[0] & 1);
        check_all("R4", 1'b0);
        check("R4 lock kept", {31'd0, lock}, 0);
    endtask

    task automatic t_lock;
        apply(1, 0, 32'h0000_0001, 0, 0, 0, 0, 0, 0, 0, 0);
        m[0] = 1;
        check("R5 lock set", {31'd0, lock}, 1);
        apply(0, 0, 0, 1, 2, 32'hDEAD_0002, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 1, 4, 32'hDEAD_0004, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 1, 1, 32'hDEAD_0001, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 1, 0, 32'h0000_5500, 0, 0, 0, 0, 0);
        m[0] = 32'h0000_5501;
        check_all("R5 locked", 1'b0);
        check("R5 lock stays", {31'd0, lock}, 1);
        apply(1, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
        m[0] = 0;
        apply(0, 0, 0, 1, 2, 32'h7777_2222, 0, 0, 0, 0, 0);
        m[2] = 32'h7777_2222;
        check("R5 unlocked", bp_addr, m[2]);
    endtask

    task automatic t_conflict;
        logic [31:0] v;
        apply(1, 6, 32'hAAAA_0006, 1, 6, 32'hBBBB_0006, 0, 0, 0, 0, 0);
        m[6] = 32'hAAAA_0006;
        check("R6 conflict", {31'd0, conflict}, 1);
        check_all("R6 host wins", 1'b1);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R6 sticky", {31'd0, conflict}, 1);
        apply(1, 0, 32'h0000_0002, 1, 7, 32'h1, 0, 0, 0, 0, 0);
        check("R6 set beats clear", {31'd0, conflict}, 1);
        apply(1, 0, 32'h0000_0002, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R6 cleared", {31'd0, conflict}, 0);
        rd(0, v);
        check("R6 ctrl bit1", v, 0);
    endtask

    task automatic t_load;
        apply(0, 0, 0, 0, 0, 0, 1, 0, 16'hBEEF, 32'hCAFE_0000, 32'h1111_1111);
        m[1] = 32'h0000_BEEF; m[2] = 32'hCAFE_0000;
        check("R8 pulse", {31'd0, bp_clobber}, 1);
        check("R9 attr", {16'd0, bp_attr}, m[1]);
        check("R9 addr", bp_addr, m[2]);
        check("R9 data", bp_data, m[4]);
        @(negedge clk);
        check("R8 one cycle", {31'd0, bp_clobber}, 0);
        check_all("R7 read load", 1'b0);
        apply(1, 2, 32'h5555_5555, 0, 0, 0, 1, 1, 16'h0042, 32'h0040_0000, 32'h2468_ACE0);
        m[1] = 32'h42; m[2] = 32'h0040_0000; m[4] = 32'h2468_ACE0;
        check("R7 load wins", bp_addr, m[2]);
        check("R7 write data", bp_data, m[4]);
        check("R6 no conflict", {31'd0, conflict}, 0);
        apply(0, 0, 0, 1, 3, 32'h9999_9999, 1, 0, 16'h0007, 32'h0000_0100, 0);
        m[1] = 7; m[2] = 32'h100;
        check("R7 proc dropped", {31'd0, conflict}, 1);
        check_all("R7 load with proc", 1'b1);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_rw();
        t_unused();
        t_proc();
        t_lock();
        t_conflict();
        t_load();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule